// File: doc/BRIEF.md
# Parallel-Signature ROM Self-Test Engine

This block checks the contents of an on-chip ROM without outside help once it has been told to start. It steps an address counter through the ROM one word per clock. Each 32-bit word that comes back is folded into a multiple-input signature register (MISR) in that same clock. The whole word is compacted at once, so no word is ever held back for a bit-by-bit checksum. When the last word has been folded in, the engine raises a done flag. A single pass flag tells whether the final signature matches a value fixed at build time.

Control arrives over a small serial test port. A one-bit update strobe copies the serial input into the run-enable bit. A 1 starts a run from idle, and a 0 written after completion returns the engine to idle. The signature register also serves as the port's data register. With the shift strobe high and no run in progress, it acts as a plain 32-bit shift register from the serial input to the serial output, so the signature can be read out for diagnosis. The ROM sits outside the block and answers combinationally on the address it is given.

Top module: `rom_sig_bist`

## Requirements
- R1: After a synchronous active-low reset, busy, done, pass and rom_rd are 0, rom_addr is 0 and the signature register holds all zeros, so the serial output reads 0.
- R2: In idle, a clock edge with tap_en_upd=1 and tap_tdi=1 starts a run. At that edge the signature register is loaded with all ones, the address is set to 0, and busy is 1 from the following cycle.
- R3: While busy, rom_rd is 1 and rom_addr takes the values 0, 1, ..., LAST_ADDR in ascending order, one per clock cycle.
- R4: Each busy cycle the signature advances as next = ({s[30:0],0} XOR (s[31] ? 32'h0040_0007 : 0)) XOR rom_data. This is feedback polynomial x^32+x^22+x^2+x+1.
- R5: done rises exactly LAST_ADDR+1 cycles after the start edge, with busy falling in the same cycle.
- R6: pass is 1 only when done is 1 and the final signature equals EXP_SIG. A ROM with any single corrupted word gives pass 0. pass keeps its value while the signature is shifted out.
- R7: With tap_shift=1 and no run in progress, each edge performs sig <= {tap_tdi, sig[31:1]} and tap_tdo shows sig[0]. 32 shifts therefore read out the signature least significant bit first.
- R8: While busy, tap_shift and tap_en_upd have no effect: the run finishes on time with an unchanged signature.
- R9: done and pass hold until tap_en_upd=1 is seen with tap_tdi=0. That update clears both and returns to idle, and an update with tap_tdi=1 while done does not restart the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_tdi | input | 1 | Serial test data in; also the value copied into the run-enable bit |
| tap_en_upd | input | 1 | Update strobe: copies tap_tdi into the run-enable bit |
| tap_shift | input | 1 | Shift strobe for the signature register |
| tap_tdo | output | 1 | Serial test data out (signature bit 0) |
| rom_addr | output | ADDR_W | ROM word address |
| rom_rd | output | 1 | ROM read enable, high during a run |
| rom_data | input | DATA_W | ROM word, valid in the cycle its address is driven |
| bist_busy | output | 1 | Run in progress |
| bist_done | output | 1 | Run complete |
| bist_pass | output | 1 | Final signature matched EXP_SIG |

## Verification
The bench drives all inputs just after a falling edge and samples just after the next one. Busy and address 0 appear one edge after the start strobe, and each later address one edge after the previous one. Done, the cleared busy and pass come LAST_ADDR+1 edges after the start strobe. Each serial output bit is read before the shift edge that replaces it. The bench walks these exact cycle counts rather than waiting for done. Expected signatures come from the bench's own model of the feedback rule, applied to a clean ROM and to ROMs with one corrupted word.

// File: rtl/rsb_pkg.sv
// Shared types and constants for the ROM signature self-test engine.
// Assumes nothing beyond a 32-bit default signature width.
package rsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bist_state_t;

    // Feedback taps x^22 + x^2 + x + 1 (the x^32 term is the shifted-out bit)
    localparam logic [31:0] RSB_POLY_DEFAULT = 32'h0040_0007;
    localparam logic [31:0] RSB_SEED_DEFAULT = 32'hFFFF_FFFF;

endpackage

// File: rtl/rsb_addr_seq.sv
// Address sequencer: holds the ROM word address, clears it to zero on a
// start request and steps it upward by one per advance until the last
// address, where it stays. Assumes LAST_ADDR fits in ADDR_W bits.
module rsb_addr_seq #(
    parameter int ADDR_W    = 6,
    parameter int LAST_ADDR = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

    // Flag the final word of the sweep
    always_comb at_last = (addr == LAST_A);

    // Address register: cleared on start, incremented while advancing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (advance && !at_last) begin
            addr <= addr + 1'b1;
        end
    end

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !at_last && !clear) |=> (addr == $past(addr) + 1'b1));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST_A);

    assert_addr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (addr == '0));

endmodule

// File: rtl/rsb_misr.sv
// Parallel multiple-input signature register. In one cycle it can load a
// seed, fold in a full data word with polynomial feedback, or act as a
// serial shift register (input at the MSB, output at bit 0). Load wins
// over compaction, and compaction wins over shifting. Assumes the caller
// never asserts compact and shift together.
module rsb_misr #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    POLY = rsb_pkg::RSB_POLY_DEFAULT,
    parameter logic [W-1:0]    SEED = rsb_pkg::RSB_SEED_DEFAULT,
    parameter logic [W-1:0]    EXP  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_seed,
    input  logic         compact,
    input  logic         shift,
    input  logic         ser_in,
    input  logic [W-1:0] word,
    output logic         ser_out,
    output logic         match_next
);
    logic [W-1:0] sig;
    logic [W-1:0] nxt;
    logic         fb;

    // Feedback bit is the stage about to leave the register
    always_comb fb = sig[W-1];

    // Next-state network: one XOR row per stage
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                assign nxt[gi] = (POLY[gi] & fb) ^ word[gi];
            end else begin : g_body
                assign nxt[gi] = sig[gi-1] ^ (POLY[gi] & fb) ^ word[gi];
            end
        end
    endgenerate

    // Serial output and final-compare result
    always_comb begin
        ser_out    = sig[0];
        match_next = (nxt == EXP);
    end

    // Signature register: seed, compact or shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig <= '0;
        end else if (load_seed) begin
            sig <= SEED;
        end else if (compact) begin
            sig <= nxt;
        end else if (shift) begin
            sig <= {ser_in, sig[W-1:1]};
        end
    end

    assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_seed |=> (sig == SEED));

    assert_shift_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load_seed && !compact) |=> (ser_out == $past(sig[1])));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_seed && !compact && !shift) |=> $stable(sig));

    assert_no_dual_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(compact && shift));

endmodule

// File: rtl/rsb_ctrl.sv
// Run controller. Reads the test-port update strobe to start a run from
// idle or to clear a finished run. Sequences the compaction phase and
// records the pass verdict on the final word. Shift requests pass through
// only when no run is active and no start is being taken.
module rsb_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic tdi,
    input  logic shift_req,
    input  logic at_last,
    input  logic match_next,
    output logic start,
    output logic run,
    output logic shift_ok,
    output logic done,
    output logic pass
);
    import rsb_pkg::*;

    bist_state_t state;
    logic        clear_req;

    // Decode strobes from the current state and test-port inputs
    always_comb begin
        start     = (state == ST_IDLE) && upd && tdi;
        clear_req = (state == ST_DONE) && upd && !tdi;
        run       = (state == ST_RUN);
        done      = (state == ST_DONE);
        shift_ok  = shift_req && !run && !start;
    end

    // State register: idle -> run -> done -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start)     state <= ST_RUN;
                ST_RUN:  if (at_last)   state <= ST_DONE;
                ST_DONE: if (clear_req) state <= ST_IDLE;
                default:                state <= ST_IDLE;
            endcase
        end
    end

    // Verdict register: captured with the last word, cleared with done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass <= 1'b0;
        end else if (run && at_last) begin
            pass <= match_next;
        end else if (clear_req || start) begin
            pass <= 1'b0;
        end
    end

    assert_pass_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> done);

    assert_run_no_escape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (run || done));

    assert_done_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(upd && !tdi)) |=> (done && $stable(pass)));

    assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && upd && !tdi) |=> (!done && !pass && !run));

    assert_state_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run, done}));

endmodule

// File: rtl/rom_sig_bist.sv
// Top level of the ROM signature self-test engine. Wires the run
// controller, the address sequencer and the parallel signature register.
// Assumes a ROM that returns rom_data combinationally for rom_addr.
// EXP_SIG is the signature of a fault-free ROM under the seed and
// polynomial given.
module rom_sig_bist #(
    parameter int                ADDR_W    = 6,
    parameter int                LAST_ADDR = 63,
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] POLY      = rsb_pkg::RSB_POLY_DEFAULT,
    parameter logic [DATA_W-1:0] SEED      = rsb_pkg::RSB_SEED_DEFAULT,
    parameter logic [DATA_W-1:0] EXP_SIG   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_tdi,
    input  logic              tap_en_upd,
    input  logic              tap_shift,
    output logic              tap_tdo,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [DATA_W-1:0] rom_data,
    output logic              bist_busy,
    output logic              bist_done,
    output logic              bist_pass
);
    logic start;
    logic run;
    logic shift_ok;
    logic at_last;
    logic match_next;

    rsb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (tap_en_upd),
        .tdi        (tap_tdi),
        .shift_req  (tap_shift),
        .at_last    (at_last),
        .match_next (match_next),
        .start      (start),
        .run        (run),
        .shift_ok   (shift_ok),
        .done       (bist_done),
        .pass       (bist_pass)
    );

    rsb_addr_seq #(
        .ADDR_W    (ADDR_W),
        .LAST_ADDR (LAST_ADDR)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .advance (run),
        .addr    (rom_addr),
        .at_last (at_last)
    );

    rsb_misr #(
        .W    (DATA_W),
        .POLY (POLY),
        .SEED (SEED),
        .EXP  (EXP_SIG)
    ) u_misr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_seed  (start),
        .compact    (run),
        .shift      (shift_ok),
        .ser_in     (tap_tdi),
        .word       (rom_data),
        .ser_out    (tap_tdo),
        .match_next (match_next)
    );

    // Read strobe and busy flag follow the run phase
    always_comb begin
        rom_rd    = run;
        bist_busy = run;
    end

    assert_busy_excl_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bist_busy && bist_done));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bist_busy && !bist_done && tap_en_upd && tap_tdi) |=> (bist_busy && rom_addr == '0));

endmodule

// File: tb/tb_rom_sig_bist.sv
module tb_rom_sig_bist;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int LAST       = 23;

    function automatic logic [31:0] base_word(input int a);
        return ((32'(a) + 32'd1) * 32'h9E37_79B1) ^ (32'(a) << 19);
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s, input logic [31:0] d);
        return ({s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0)) ^ d;
    endfunction

    function automatic logic [31:0] model_sig(input logic fon, input int fa, input logic [31:0] fm);
        logic [31:0] s;
        s = 32'hFFFF_FFFF;
        for (int a = 0; a <= LAST; a++)
            s = step(s, base_word(a) ^ ((fon && a == fa) ? fm : 32'h0));
        return s;
    endfunction

    localparam logic [31:0] GOLD = model_sig(1'b0, 0, 32'h0);

    // Vector table: {fault_on, fault_addr[4:0], fault_mask[31:0]}
    localparam int NVEC = 4;
    localparam logic [37:0] VECS [NVEC] = '{
        {1'b0, 5'd0,  32'h0000_0000},
        {1'b1, 5'd0,  32'h0000_0001},
        {1'b1, 5'd23, 32'h8000_0000},
        {1'b1, 5'd11, 32'h0F00_00F0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tap_tdi = 1'b0;
    logic              tap_en_upd = 1'b0;
    logic              tap_shift = 1'b0;
    logic              tap_tdo;
    logic [ADDR_W-1:0] rom_addr;
    logic              rom_rd;
    logic [31:0]       rom_data;
    logic              bist_busy;
    logic              bist_done;
    logic              bist_pass;

    logic              fault_on = 1'b0;
    logic [ADDR_W-1:0] fault_addr = '0;
    logic [31:0]       fault_mask = '0;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural ROM with optional single-word fault
    always_comb rom_data = base_word(int'(rom_addr)) ^
                           ((fault_on && rom_addr == fault_addr) ? fault_mask : 32'h0);

    rom_sig_bist #(
        .ADDR_W    (ADDR_W),
        .LAST_ADDR (LAST),
        .DATA_W    (32),
        .EXP_SIG   (GOLD)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tap_tdi    (tap_tdi),
        .tap_en_upd (tap_en_upd),
        .tap_shift  (tap_shift),
        .tap_tdo    (tap_tdo),
        .rom_addr   (rom_addr),
        .rom_rd     (rom_rd),
        .rom_data   (rom_data),
        .bist_busy  (bist_busy),
        .bist_done  (bist_done),
        .bist_pass  (bist_pass)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic run_bist(input bit disturb);
        logic seq_ok;
        tap_en_upd = 1'b1; tap_tdi = 1'b1;
        @(negedge clk);
        tap_en_upd = 1'b0; tap_tdi = 1'b0;
        chk("R2 busy after start", 32'(bist_busy), 32'd1);
        seq_ok = 1'b1;
        for (int k = 0; k <= LAST; k++) begin
            if (rom_addr !== ADDR_W'(k) || rom_rd !== 1'b1 || bist_busy !== 1'b1 || bist_done !== 1'b0)
                seq_ok = 1'b0;
            if (disturb) begin
                if (k == 2) begin tap_shift = 1'b1; tap_tdi = 1'b1; end
                if (k == 3) begin tap_shift = 1'b0; tap_en_upd = 1'b1; tap_tdi = 1'b0; end
                if (k == 4) begin tap_en_upd = 1'b0; tap_tdi = 1'b0; end
            end
            @(negedge clk);
        end
        chk("R3 ascending address sweep", 32'(seq_ok), 32'd1);
        chk("R5 done after LAST+1 cycles", 32'(bist_done), 32'd1);
        chk("R5 busy low at done", 32'(bist_busy), 32'd0);
    endtask

    task automatic read_sig(output logic [31:0] s);
        tap_shift = 1'b1; tap_tdi = 1'b0;
        for (int i = 0; i < 32; i++) begin
            s[i] = tap_tdo;
            @(negedge clk);
        end
        tap_shift = 1'b0;
    endtask

    task automatic clear_en();
        tap_en_upd = 1'b1; tap_tdi = 1'b0;
        @(negedge clk);
        tap_en_upd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] sig;
        logic [31:0] pat;
        logic [31:0] exp_sig;
        logic        zeros_ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", 32'(bist_busy), 32'd0);
        chk("R1 done", 32'(bist_done), 32'd0);
        chk("R1 pass", 32'(bist_pass), 32'd0);
        chk("R1 rom_rd", 32'(rom_rd), 32'd0);
        chk("R1 rom_addr", 32'(rom_addr), 32'd0);

        // R1/R7: shift a pattern in while reading zeros, then read it back
        pat = 32'hA5C3_1E97;
        zeros_ok = 1'b1;
        tap_shift = 1'b1;
        for (int i = 0; i < 32; i++) begin
            tap_tdi = pat[i];
            if (tap_tdo !== 1'b0) zeros_ok = 1'b0;
            @(negedge clk);
        end
        tap_shift = 1'b0;
        chk("R1 signature register zero after reset", 32'(zeros_ok), 32'd1);
        read_sig(sig);
        chk("R7 idle shift round trip", sig, pat);

        // Table walk: clean and faulted ROMs
        for (int v = 0; v < NVEC; v++) begin
            fault_on   = VECS[v][37];
            fault_addr = VECS[v][36:32];
            fault_mask = VECS[v][31:0];
            exp_sig    = model_sig(fault_on, int'(fault_addr), fault_mask);
            clear_en();
            run_bist(1'b0);
            chk("R6 pass verdict", 32'(bist_pass), 32'(exp_sig == GOLD));
            read_sig(sig);
            chk("R4 signature readout", sig, exp_sig);
            chk("R6 pass held over readout", 32'(bist_pass), 32'(exp_sig == GOLD));
        end
        fault_on = 1'b0;

        // R8: strobes during a run are ignored
        clear_en();
        run_bist(1'b1);
        chk("R8 pass despite strobes", 32'(bist_pass), 32'd1);
        read_sig(sig);
        chk("R8 signature unchanged by strobes", sig, GOLD);

        // R9: enable=1 while done does not restart; enable=0 clears
        tap_en_upd = 1'b1; tap_tdi = 1'b1;
        @(negedge clk);
        tap_en_upd = 1'b0; tap_tdi = 1'b0;
        chk("R9 no restart while done (busy)", 32'(bist_busy), 32'd0);
        chk("R9 done held", 32'(bist_done), 32'd1);
        chk("R9 pass held", 32'(bist_pass), 32'd1);
        clear_en();
        chk("R9 done cleared", 32'(bist_done), 32'd0);
        chk("R9 pass cleared", 32'(bist_pass), 32'd0);

        // R1: reset in the middle of a run
        tap_en_upd = 1'b1; tap_tdi = 1'b1;
        @(negedge clk);
        tap_en_upd = 1'b0; tap_tdi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 busy after mid-run reset", 32'(bist_busy), 32'd0);
        chk("R1 addr after mid-run reset", 32'(rom_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R5: fresh run after reset still produces the golden result
        run_bist(1'b0);
        chk("R6 pass after reset recovery", 32'(bist_pass), 32'd1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule